// File: doc/BRIEF.md
# Shift-Down Conversion Result FIFO

This block buffers converter results between the converter's end-of-conversion write and the system's reads. It has eight slots. Each stored word holds a 12-bit sample and a one-bit out-of-range flag.

Words are not addressed by circular pointers. A new word goes into the slot just above the highest occupied slot. The output is always taken from slot 0. When a read is accepted, every stored word moves one slot toward slot 0. A single occupancy counter tracks how many slots hold valid data.

Writes, reads and the shifting of words all happen on the rising edge of one clock. The producer and the consumer must therefore share that clock.

Top module: `shiftdown_result_fifo`

## Requirements
- R1: The FIFO holds up to 8 words of 13 bits each: a 12-bit sample and a 1-bit out-of-range flag. Words leave in the order they were written.
- R2: An accepted write with no accepted read stores the word in the slot just above the highest valid slot, and the occupancy rises by one.
- R3: While the FIFO is not empty, `rd_sample` and `rd_range` always show the word in slot 0, which is the oldest stored word. There is no read latency.
- R4: An accepted read (`rd_en` high while not empty) moves every stored word down one slot, and the occupancy falls by one at the next rising edge.
- R5: A read and a write in the same cycle on a non-empty FIFO leave the occupancy unchanged and keep write order. This also holds when the FIFO is full: the write is accepted and `overflow` is not set.
- R6: A write while the FIFO is full and no read is requested is dropped. It sets `overflow`, which stays high until reset.
- R7: A read while the FIFO is empty has no effect: the occupancy stays at zero and `rd_sample`/`rd_range` keep their values. A write in that same cycle is still stored.
- R8: `empty` is high exactly when the occupancy is 0. `full` is high exactly when the occupancy is 8.
- R9: A synchronous active-high `rst` empties the FIFO and clears `overflow`. It also drives `rd_sample` and `rd_range` to zero and `full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for writes, reads and shifting |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write a result this cycle |
| wr_sample | input | 12 | Sample value to write |
| wr_range | input | 1 | Out-of-range flag to write |
| rd_en | input | 1 | Consume the word at slot 0 this cycle |
| rd_sample | output | 12 | Sample held in slot 0 |
| rd_range | output | 1 | Out-of-range flag held in slot 0 |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is eight |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
The hardest cases to reach are a read and a write landing on the same edge while the FIFO is exactly full, and the same pair while it is exactly empty. Both need the occupancy steered to a boundary first.

Directed phases fill the FIFO to eight and then issue combined reads and writes there. They drain it to zero and issue empty reads, both alone and paired with writes.

A long random phase then runs with read and write probabilities that change from segment to segment. This lets the occupancy sit at either end for many cycles. Every output is compared each cycle with a queue model kept in the bench.

// File: rtl/sdfifo_pkg.sv
package sdfifo_pkg;

    localparam int SAMPLE_W  = 12;
    localparam int FIFO_SLOTS = 8;

    typedef struct packed {
        logic                range_err;
        logic [SAMPLE_W-1:0] sample;
    } result_t;

    localparam int WORD_W = $bits(result_t);

    function automatic result_t make_result(input logic [SAMPLE_W-1:0] s,
                                            input logic r);
        result_t w;
        w.range_err = r;
        w.sample    = s;
        return w;
    endfunction

    localparam result_t RESULT_ZERO = '0;

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
    import sdfifo_pkg::*;
#(
    parameter int DEPTH = FIFO_SLOTS,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             shift_en,
    output logic [DEPTH-1:0] wr_sel,
    output logic             is_empty,
    output logic             is_full,
    output logic             ovf_sticky
);

    localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP
    } op_e;

    logic [PTR_W-1:0] level_q, level_d;
    logic [PTR_W-1:0] wr_slot;
    logic             rd_ok, wr_ok, wr_drop;
    op_e              op;

    // A read is honoured only when something is stored.
    // A write is honoured when there is room, or when a read frees a slot on the same edge.
    assign rd_ok   = rd_req && (level_q != '0);
    assign wr_ok   = wr_req && ((level_q != PTR_FULL) || rd_ok);
    assign wr_drop = wr_req && !wr_ok;

    always_comb begin
        unique case ({wr_ok, rd_ok})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        level_d = level_q;
        wr_slot = level_q;
        unique case (op)
            OP_PUSH: level_d = level_q + PTR_ONE;
            OP_POP:  level_d = level_q - PTR_ONE;
            OP_SWAP: wr_slot = level_q - PTR_ONE;  // contents shift, new word lands one below
            default: ;
        endcase
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_sel
            assign wr_sel[i] = wr_ok && (wr_slot == PTR_W'(i));
        end
    endgenerate

    assign shift_en = rd_ok;
    assign is_empty = (level_q == '0);
    assign is_full  = (level_q == PTR_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q    <= '0;
            ovf_sticky <= 1'b0;
        end else begin
            level_q <= level_d;
            if (wr_drop) begin
                ovf_sticky <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdf_slot_array.sv
module sdf_slot_array
    import sdfifo_pkg::*;
#(
    parameter int DEPTH = FIFO_SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [DEPTH-1:0] wr_sel,
    input  result_t          wr_word,
    output result_t          bottom_word
);

    result_t slot_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            result_t above;
            if (i == DEPTH - 1) begin : g_top
                assign above = slot_q[i];
            end else begin : g_mid
                assign above = slot_q[i+1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[i] <= RESULT_ZERO;
                end else if (wr_sel[i]) begin
                    slot_q[i] <= wr_word;
                end else if (shift_en) begin
                    slot_q[i] <= above;
                end
            end
        end
    endgenerate

    assign bottom_word = slot_q[0];

endmodule

// File: rtl/shiftdown_result_fifo.sv
module shiftdown_result_fifo
    import sdfifo_pkg::*;
#(
    parameter int DEPTH = FIFO_SLOTS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_sample,
    input  logic                wr_range,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_sample,
    output logic                rd_range,
    output logic                empty,
    output logic                full,
    output logic                overflow
);

    logic             shift_en;
    logic [DEPTH-1:0] wr_sel;
    result_t          bottom;

    sdf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_en),
        .rd_req     (rd_en),
        .shift_en   (shift_en),
        .wr_sel     (wr_sel),
        .is_empty   (empty),
        .is_full    (full),
        .ovf_sticky (overflow)
    );

    sdf_slot_array #(.DEPTH(DEPTH)) u_slots (
        .clk         (clk),
        .rst         (rst),
        .shift_en    (shift_en),
        .wr_sel      (wr_sel),
        .wr_word     (make_result(wr_sample, wr_range)),
        .bottom_word (bottom)
    );

    assign rd_sample = bottom.sample;
    assign rd_range  = bottom.range_err;

endmodule

// File: rtl/sdf_checker.sv
module sdf_checker
    import sdfifo_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                rd_en,
    input logic [SAMPLE_W-1:0] rd_sample,
    input logic                rd_range,
    input logic                empty,
    input logic                full,
    input logic                overflow
);

    // R8: both flags can never be high together
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R2: a lone write into an empty FIFO makes it non-empty
    a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en && !rd_en) |=> !empty);

    // R4: a lone read from a full FIFO frees a slot
    a_r4_read_frees: assert property (@(posedge clk) disable iff (rst)
        (full && rd_en && !wr_en) |=> !full);

    // R5: a combined read and write at full keeps the FIFO full and sets no overflow
    a_r5_swap_at_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en && !overflow) |=> (full && !overflow));

    // R6: a dropped write raises overflow
    a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> overflow);

    // R6: overflow is sticky
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7: a lone read while empty changes nothing
    a_r7_empty_read: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_sample) && $stable(rd_range)));

    // R9: after reset the block is empty and clean
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (empty && !full && !overflow && rd_sample == '0 && !rd_range));

endmodule

bind shiftdown_result_fifo sdf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_sample (rd_sample),
    .rd_range  (rd_range),
    .empty     (empty),
    .full      (full),
    .overflow  (overflow)
);

// File: tb/shiftdown_result_fifo_test.sv
`timescale 1ns/1ps
module shiftdown_result_fifo_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_sample = '0;
    logic        wr_range = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_sample;
    logic        rd_range;
    logic        empty, full, overflow;

    int checks = 0;
    int errors = 0;

    logic [12:0] model_q[$];
    logic        model_ovf = 1'b0;
    logic [12:0] prev_out = '0;
    logic        prev_empty = 1'b1;
    logic        prev_lone_rd = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    shiftdown_result_fifo uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sample(wr_sample),
        .wr_range(wr_range), .rd_en(rd_en), .rd_sample(rd_sample),
        .rd_range(rd_range), .empty(empty), .full(full), .overflow(overflow)
    );

    function automatic bit exp_empty(int n); return n == 0; endfunction
    function automatic bit exp_full(int n);  return n == 8; endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the model (called away from the rising edge)
    task automatic compare_all();
        logic [12:0] out;
        out = {rd_range, rd_sample};
        check(empty == exp_empty(model_q.size()), "R8 empty", empty, exp_empty(model_q.size()));
        check(full == exp_full(model_q.size()), "R8 full", full, exp_full(model_q.size()));
        check(overflow == model_ovf, "R6 overflow", overflow, model_ovf);
        if (model_q.size() > 0)
            check(out == model_q[0], "R3 head word", out, model_q[0]);
        else if (prev_empty && prev_lone_rd)
            check(out == prev_out, "R7 empty read keeps output", out, prev_out);
        prev_out   = out;
        prev_empty = (model_q.size() == 0);
    endtask

    // Drive one cycle at negedge; the model advances as of the next rising edge
    task automatic step(input bit w, input bit r, input logic [12:0] d);
        bit rd_ok, wr_ok;
        wr_en = w; rd_en = r; {wr_range, wr_sample} = d;
        rd_ok = r && model_q.size() > 0;
        wr_ok = w && (model_q.size() < 8 || rd_ok);
        prev_lone_rd = r && !w;
        if (rd_ok) void'(model_q.pop_front());
        if (wr_ok) model_q.push_back(d);
        if (w && !wr_ok) model_ovf = 1'b1;
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rd_en = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_q.delete(); model_ovf = 1'b0;
        // R9: reset state
        check(empty === 1'b1, "R9 empty after reset", empty, 1);
        check(full === 1'b0, "R9 full after reset", full, 0);
        check(overflow === 1'b0, "R9 overflow after reset", overflow, 0);
        check({rd_range, rd_sample} === 13'h0, "R9 output zero after reset",
              {rd_range, rd_sample}, 0);
        prev_out = '0; prev_empty = 1'b1; prev_lone_rd = 1'b0;
    endtask

    initial begin
        int wp, rp;
        void'($urandom(32'h5D0F1F0));
        @(negedge clk);
        do_reset();

        // R1, R2: fill to eight with distinct words
        for (int i = 0; i < 8; i++) step(1, 0, 13'(12'h100 + i) | ((i % 2) ? 13'h1000 : 13'h0));
        check(model_q.size() == 8 && full, "R1 eight slots", full, 1);
        // R6: drop while full
        step(1, 0, 13'h0ABC);
        step(1, 0, 13'h1DEF);
        // R5: combined read and write while full
        step(1, 1, 13'h1777);
        step(1, 1, 13'h0555);
        // R4, R3: drain in order
        for (int i = 0; i < 9; i++) step(0, 1, 13'h0);
        // R7: empty reads, alone and with a write
        step(0, 1, 13'h0);
        step(0, 1, 13'h0);
        step(1, 1, 13'h1234);
        step(1, 1, 13'h0321);   // R5: one stored, combined keeps one
        step(0, 1, 13'h0);
        step(0, 1, 13'h0);

        // R9: reset clears the sticky overflow
        do_reset();

        // Random segments with shifting probabilities
        for (int seg = 0; seg < 40; seg++) begin
            wp = $urandom_range(10, 90);
            rp = $urandom_range(10, 90);
            for (int c = 0; c < 100; c++)
                step(($urandom_range(0, 99) < wp), ($urandom_range(0, 99) < rp),
                     13'($urandom));
        end
        do_reset();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule